// File: doc/BRIEF.md
# Single-wire debug host bit receiver

This block is the initiating side of a one-wire debug link, used to read bits back from a target. For each bit the host pulls the shared line low to mark the bit start. It lets go before the target's speed-up pulse can arrive, and the target finishes the bit. A target sending a zero holds the line low past the sample point. A target sending a one leaves the line high. The host samples the line at a fixed offset from the bit start.

A transfer starts with a `start` pulse and a requested bit count. The bits follow each other with no gap. The host samples each bit and shifts it into a register, first bit most significant. When the last bit period ends, the word is presented on `data_out` and `done` pulses for one clock.

All timing is counted in clock cycles, and the clock is taken to run at the target's rate. The low-drive length, the sample offset and the bit period are parameters, with defaults of 4, 10 and 16 cycles. The line input passes through a two-flop synchroniser, and the sampling point is moved later by those two cycles. The value taken is therefore the line level exactly `SAMPLE_CYC` cycles after the bit start. The parameters must satisfy `DRIVE_CYC < SAMPLE_CYC` and `SAMPLE_CYC + 2 < BIT_CYC - 1`.

Top module: `dbg_bit_rx`

## Requirements
- R1: After reset, `drive_low`, `done` and `data_out` are all zero.
- R2: When the block is idle and `start` is sampled high with `nbits` in the range 1 to `DATA_W`, the first bit period begins in the next cycle, and `drive_low` is high in that cycle.
- R3: In every bit period, `drive_low` is high for exactly the first `DRIVE_CYC` cycles and low for the remaining cycles of the `BIT_CYC`-cycle period.
- R4: The value received for a bit is the level of `line_in` in the cycle `SAMPLE_CYC` cycles after that bit period began. A high level is a one and a low level is a zero. The level in every other cycle of the period has no effect.
- R5: The received word is right-aligned in `data_out`, with the first received bit in position `nbits-1` and the last in position 0. The bits above `nbits-1` are zero.
- R6: `done` is high for exactly one cycle, in the cycle after the last bit period ends. `data_out` takes the new word in that same cycle and holds it until the next `done`.
- R7: A `start` with `nbits` equal to 0 or greater than `DATA_W` is ignored: no drive, no `done`, and `data_out` is unchanged.
- R8: A `start` pulse during a transfer is ignored, and the transfer in progress completes with its original bit count.
- R9: Consecutive bit periods follow back to back, so that an `n`-bit transfer takes exactly `n*BIT_CYC` cycles from its first bit start to `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at the target-equivalent cycle rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to begin a transfer |
| nbits | input | CNT_W | Number of bits to receive (1 to DATA_W) |
| line_in | input | 1 | Level of the debug line |
| drive_low | output | 1 | High while the host pulls the line low |
| data_out | output | DATA_W | Last received word, right-aligned |
| done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The bench builds the block with an 8-bit word, a 3-cycle low drive, a sample offset of 7 and an 11-cycle bit period. These are short values, so many full-width and single-bit transfers fit in the run. The 4-bit `nbits` port can then carry counts above the word width, and the bench exercises those rejected requests. The simulated target presents each bit's true level only in the single sampling cycle and the inverse in every other released cycle. Any shift of the sampling point or of the synchroniser compensation therefore shows up as corrupted data.

// File: rtl/dbg_bit_rx.sv
module dbg_bit_rx #(
  parameter int DATA_W     = 16,
  parameter int DRIVE_CYC  = 4,
  parameter int SAMPLE_CYC = 10,
  parameter int BIT_CYC    = 16,
  localparam int CNT_W = $clog2(DATA_W + 1),
  localparam int CYC_W = $clog2(BIT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  nbits,
  input  logic              line_in,
  output logic              drive_low,
  output logic [DATA_W-1:0] data_out,
  output logic              done
);
  localparam logic [CNT_W-1:0] MAX_N    = CNT_W'(DATA_W);
  localparam logic [CYC_W-1:0] DRV_N    = CYC_W'(DRIVE_CYC);
  localparam logic [CYC_W-1:0] SMP_AT   = CYC_W'(SAMPLE_CYC + 2);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(BIT_CYC - 1);

  logic [1:0]        sync;
  logic              busy;
  logic [CYC_W-1:0]  cyc;
  logic [CNT_W-1:0]  bitcnt;
  logic [CNT_W-1:0]  nb;
  logic [DATA_W-1:0] shreg;

  wire nbits_ok = (nbits != '0) && (nbits <= MAX_N);
  wire last_bit = (bitcnt == nb - CNT_W'(1));

  assign drive_low = busy && (cyc < DRV_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync     <= 2'b11;
      busy     <= 1'b0;
      cyc      <= '0;
      bitcnt   <= '0;
      nb       <= '0;
      shreg    <= '0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      sync <= {sync[0], line_in};
      done <= 1'b0;
      if (!busy) begin
        cyc    <= '0;
        bitcnt <= '0;
        if (start && nbits_ok) begin
          busy  <= 1'b1;
          nb    <= nbits;
          shreg <= '0;
        end
      end else begin
        if (cyc == SMP_AT)
          shreg <= {shreg[DATA_W-2:0], sync[1]};
        if (cyc == LAST_CYC) begin
          cyc <= '0;
          if (last_bit) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            data_out <= shreg;
          end else begin
            bitcnt <= bitcnt + CNT_W'(1);
          end
        end else begin
          cyc <= cyc + CYC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dbg_bit_rx_chk.sv
module dbg_bit_rx_chk #(
  parameter int DATA_W    = 16,
  parameter int DRIVE_CYC = 4,
  parameter int CNT_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  nbits,
  input logic              busy,
  input logic              drive_low,
  input logic [DATA_W-1:0] data_out,
  input logic              done
);
  int run;
  wire ok_n = (nbits != '0) && (int'(nbits) <= DATA_W);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= 0;
    else        run <= drive_low ? run + 1 : 0;

  assert_drive_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> run < DRIVE_CYC);
  assert_start_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ok_n) |=> drive_low);
  assert_bad_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !ok_n) |=> (!busy && !drive_low));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(data_out));
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !drive_low));
endmodule

bind dbg_bit_rx dbg_bit_rx_chk #(
  .DATA_W(DATA_W), .DRIVE_CYC(DRIVE_CYC), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits), .busy(busy),
  .drive_low(drive_low), .data_out(data_out), .done(done)
);

// File: tb/dbg_bit_rx_tb.sv
module dbg_bit_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int DRV = 3;
  localparam int SMP = 7;
  localparam int BIT = 11;
  localparam int CW  = $clog2(DW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] nbits = '0;
  logic tgt = 1'b1;
  logic drive_low;
  logic [DW-1:0] data_out;
  logic done;
  wire line_in = drive_low ? 1'b0 : tgt;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bit_rx #(.DATA_W(DW), .DRIVE_CYC(DRV), .SAMPLE_CYC(SMP), .BIT_CYC(BIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .nbits(nbits), .line_in(line_in),
    .drive_low(drive_low), .data_out(data_out), .done(done));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_word(input int n, input logic [DW-1:0] bits);
    logic [DW-1:0] w = '0;
    for (int i = n - 1; i >= 0; i--) w = {w[DW-2:0], bits[i]};
    return w;
  endfunction

  task automatic xfer(input int n, input logic [DW-1:0] bits, input bit poke);
    int drv_bad = 0;
    int early_done = 0;
    logic [DW-1:0] exp = expect_word(n, bits);
    start = 1'b1;
    nbits = CW'(n);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int b = n - 1; b >= 0; b--) begin
      for (int k = 0; k < BIT; k++) begin
        if (drive_low !== (k < DRV)) drv_bad++;
        if (done !== 1'b0) early_done++;
        tgt = (k == SMP) ? bits[b] : ~bits[b];
        if (poke && b == n - 1 && k == 5) begin start = 1'b1; nbits = CW'(1); end
        else start = 1'b0;
        @(posedge clk); @(negedge clk);
      end
    end
    tgt = 1'b1;
    chk(drv_bad == 0, "R3 drive window", drv_bad, 0);
    chk(early_done == 0, "R9 no done before last period", early_done, 0);
    chk(done === 1'b1, "R6 done after last bit", done, 1);
    chk(data_out === exp, poke ? "R8 start while busy ignored" : "R4 R5 received word", data_out, exp);
    chk(drive_low === 1'b0, "R6 idle at done", drive_low, 0);
    last_word = exp;
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0 && data_out === exp, "R6 one-cycle done, data held", {done, data_out}, {1'b0, exp});
  endtask

  task automatic bad_start(input int n);
    int act = 0;
    start = 1'b1;
    nbits = CW'(n);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3 * BIT; k++) begin
      if (drive_low || done) act++;
      @(posedge clk); @(negedge clk);
    end
    chk(act == 0 && data_out === last_word, "R7 bad count ignored", act, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(drive_low === 0 && done === 0 && data_out === '0, "R1 reset state",
        {drive_low, done, data_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(drive_low === 1'b0, "R1 idle after reset", drive_low, 0);
    xfer(1, 8'h01, 1'b0);
    xfer(1, 8'h00, 1'b0);
    xfer(DW, 8'hFF, 1'b0);
    xfer(DW, 8'h00, 1'b0);
    xfer(DW, 8'hA5, 1'b0);
    xfer(5, 8'h13, 1'b0);
    bad_start(0);
    bad_start(DW + 1);
    bad_start(15);
    xfer(4, 8'h09, 1'b1);
    for (int i = 0; i < 25; i++) begin
      int n = 1 + int'($urandom % DW);
      xfer(n, DW'($urandom), 1'b0);
      repeat ($urandom % 3) @(negedge clk);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule